// File: doc/BRIEF.md
# Float Import Register File

This block sits where memory words enter a small floating-point register file. Each write carries a 64-bit data word and a precision select. The word is read either as a 32-bit IEEE single-precision value in its low half or as a full 64-bit IEEE double-precision value. The block widens the word into one 96-bit internal word and stores it. That word has an explicit integer bit, an 11-bit exponent biased by 1023 and a 52-bit fraction field. Two tag bits record whether the operand arrived as a single-precision denormal or as a double-precision denormal.

There are two combinational read ports. The move port returns the stored 96-bit word unchanged, so values can be copied between registers. The operand port returns the word as an arithmetic unit consumes it. On that port the low 21 bits of the fraction field are cleared by plain truncation, with no rounding, which leaves a 31-bit fraction.

A single-precision denormal is normalized during the write. A leading-zero count sets the shift, and the exponent drops by the same amount, so that its integer bit becomes 1. A double-precision denormal does not fit the 11-bit exponent range after normalization. It is therefore kept as it arrived, with a zero exponent and a zero integer bit. The block does no arithmetic, no rounding and no conversion back to memory formats, and it raises no exception flags.

Top module: `fpimp_regfile`

## Requirements
- R1: Every stored word uses this layout: sign at bit 95, single-denormal tag at bit 94, double-denormal tag at bit 93, exponent at 74:64, integer bit at 63 and fraction at 62:11. Bits 92:75 and 10:0 always read as zero.
- R2: A single-precision normal input (exponent field 1..254) is stored as follows. The exponent is the field plus 896, the integer bit is 1, and the 23 fraction bits go to bits 62:40. Bits 39:11 are zero.
- R3: A single-precision zero is stored with exponent 0, integer bit 0 and fraction 0. An input with exponent field 255 is stored with exponent 2047 and integer bit 1, and its 23 fraction bits (the NaN payload) go to bits 62:40.
- R4: A single-precision denormal with fraction f is normalized. Let k be the number of leading zeros of f in its 23-bit field. The stored exponent is 896 − k and the integer bit is 1. The fraction holds f shifted left by k+1, with the bits below it zero.
- R5: The single-denormal tag (bit 94) is 1 only after a single-precision denormal write. The double-denormal tag (bit 93) is 1 only after a double-precision denormal write. Every other write clears both tags.
- R6: A double-precision input whose exponent field is nonzero keeps its 11-bit exponent and all 52 fraction bits, with integer bit 1. A double-precision zero is stored as all zeros except the sign.
- R7: A double-precision denormal (exponent 0, fraction nonzero) is stored with exponent 0, integer bit 0, the 52 fraction bits unchanged and the double-denormal tag set.
- R8: The operand port equals the stored word except that bits 31:11 are zero. The 21 low fraction bits are dropped with no rounding.
- R9: A write becomes visible on both read ports only after the next rising clock edge. The read ports follow their address inputs with no clock.
- R10: In single-precision mode, wr_data[63:32] has no effect on the stored word.
- R11: A write to an address of 10 or above changes no entry, and a read of such an address returns zero.
- R12: While reset is asserted, and after it is released, every entry holds zero until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write entry index |
| wr_dbl | input | 1 | 1: double precision in wr_data[63:0]; 0: single precision in wr_data[31:0] |
| wr_data | input | 64 | Memory word to convert |
| mv_addr | input | 4 | Move read port index |
| mv_data | output | 96 | Stored internal word |
| op_addr | input | 4 | Operand read port index |
| op_data | output | 96 | Stored word with fraction truncated to 31 bits |

## Verification
A wrong conversion or a corrupted entry appears on the move port in the first cycle after the write's clock edge. It also appears on the operand port in every field above bit 31. The bench therefore reads each entry back immediately after writing it. A bad exponent rebias or leading-zero count shows as an exponent that is off by a fixed amount. A tag set or cleared at the wrong time shows in bits 94:93. Both read ports are combinational, so a mismatch is visible within the same cycle in which the address is presented.

// File: rtl/fpimp_pkg.sv
package fpimp_pkg;

    localparam int XW       = 96;
    localparam int EXPW     = 11;
    localparam int FRACW    = 52;
    localparam int SP_EXPW  = 8;
    localparam int SP_FRACW = 23;
    localparam int OP_FRACW = 31;
    localparam int DROPW    = FRACW - OP_FRACW;
    localparam int SP_PADW  = FRACW - SP_FRACW;

    // rebias from 127 to 1023
    localparam logic [EXPW-1:0] SP_REBIAS = 11'd896;
    localparam logic [EXPW-1:0] EXP_MAX   = '1;

    typedef struct packed {
        logic             sign;
        logic             sp_dn;
        logic             dp_dn;
        logic [17:0]      pad_hi;
        logic [EXPW-1:0]  bexp;
        logic             ibit;
        logic [FRACW-1:0] frac;
        logic [10:0]      pad_lo;
    } xword_t;

endpackage

// File: rtl/fpimp_lzc.sv
module fpimp_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpimp_convert.sv
module fpimp_convert
    import fpimp_pkg::*;
(
    input  logic         dbl,
    input  logic [63:0]  din,
    output xword_t       word
);
    localparam int LZW = $clog2(SP_FRACW + 1);

    logic [SP_EXPW-1:0]  sp_e;
    logic [SP_FRACW-1:0] sp_f;
    logic [EXPW-1:0]     dp_e;
    logic [FRACW-1:0]    dp_f;
    logic [LZW-1:0]      lz;
    logic [SP_FRACW-1:0] sp_norm;

    assign sp_e = din[30:23];
    assign sp_f = din[22:0];
    assign dp_e = din[62:52];
    assign dp_f = din[51:0];

    fpimp_lzc #(.W(SP_FRACW), .CW(LZW)) u_lzc (
        .vec (sp_f),
        .cnt (lz)
    );

    // leading one leaves the field; the rest becomes the fraction
    assign sp_norm = sp_f << (lz + LZW'(1));

    always_comb begin
        word = '0;
        if (dbl) begin
            word.sign = din[63];
            word.bexp = dp_e;
            word.frac = dp_f;
            if (dp_e == '0) begin
                word.ibit  = 1'b0;
                word.dp_dn = (dp_f != '0);
            end else begin
                word.ibit  = 1'b1;
            end
        end else begin
            word.sign = din[31];
            if (sp_e == '0) begin
                if (sp_f != '0) begin
                    word.sp_dn = 1'b1;
                    word.ibit  = 1'b1;
                    word.bexp  = SP_REBIAS - EXPW'(lz);
                    word.frac  = {sp_norm, {SP_PADW{1'b0}}};
                end
            end else if (sp_e == '1) begin
                word.bexp = EXP_MAX;
                word.ibit = 1'b1;
                word.frac = {sp_f, {SP_PADW{1'b0}}};
            end else begin
                word.bexp = EXPW'(sp_e) + SP_REBIAS;
                word.ibit = 1'b1;
                word.frac = {sp_f, {SP_PADW{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/fpimp_bank.sv
module fpimp_bank
    import fpimp_pkg::*;
#(
    parameter int NREG = 10,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  xword_t        wword,
    input  logic [AW-1:0] raddr_a,
    output xword_t        rword_a,
    input  logic [AW-1:0] raddr_b,
    output xword_t        rword_b
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(NREG);

    xword_t mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && waddr == AW'(g)) begin
                mem[g] <= wword;
            end
        end
    end

    assign rword_a = ({1'b0, raddr_a} < LIMIT) ? mem[raddr_a] : '0;
    assign rword_b = ({1'b0, raddr_b} < LIMIT) ? mem[raddr_b] : '0;
endmodule

// File: rtl/fpimp_regfile.sv
module fpimp_regfile
    import fpimp_pkg::*;
#(
    parameter int NREG = 10,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_dbl,
    input  logic [63:0]   wr_data,
    input  logic [AW-1:0] mv_addr,
    output logic [95:0]   mv_data,
    input  logic [AW-1:0] op_addr,
    output logic [95:0]   op_data
);
    xword_t cvt_word;
    xword_t mv_word;
    xword_t op_raw;
    xword_t op_word;

    fpimp_convert u_cvt (
        .dbl  (wr_dbl),
        .din  (wr_data),
        .word (cvt_word)
    );

    fpimp_bank #(.NREG(NREG), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wword   (cvt_word),
        .raddr_a (mv_addr),
        .rword_a (mv_word),
        .raddr_b (op_addr),
        .rword_b (op_raw)
    );

    // operand view: low fraction bits dropped, no rounding
    always_comb begin
        op_word = op_raw;
        op_word.frac[DROPW-1:0] = '0;
    end

    assign mv_data = mv_word;
    assign op_data = op_word;
endmodule

// File: rtl/fpimp_regfile_chk.sv
module fpimp_regfile_chk #(
    parameter int NREG = 10,
    parameter int AW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          wr_dbl,
    input logic [63:0]   wr_data,
    input logic [AW-1:0] mv_addr,
    input logic [95:0]   mv_data,
    input logic [AW-1:0] op_addr,
    input logic [95:0]   op_data
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(NREG);

    logic wvalid;
    logic sp_dn_in;
    logic dp_dn_in;
    logic sp_norm_in;
    logic sign_in;
    assign wvalid     = wr_en && ({1'b0, wr_addr} < LIMIT);
    assign sp_dn_in   = !wr_dbl && wr_data[30:23] == 8'd0 && wr_data[22:0] != 23'd0;
    assign dp_dn_in   = wr_dbl && wr_data[62:52] == 11'd0 && wr_data[51:0] != 52'd0;
    assign sp_norm_in = !wr_dbl && wr_data[30:23] != 8'd0 && wr_data[30:23] != 8'hFF;
    assign sign_in    = wr_dbl ? wr_data[63] : wr_data[31];

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mv_data[92:75] == 18'd0 && mv_data[10:0] == 11'd0);

    assert_tags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mv_data[94:93]));

    assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |=> (mv_addr != $past(wr_addr)) || (mv_data[95] == $past(sign_in)));

    assert_sp_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |=> (mv_addr != $past(wr_addr)) || (mv_data[94] == $past(sp_dn_in)));

    assert_dp_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |=> (mv_addr != $past(wr_addr)) || (mv_data[93] == $past(dp_dn_in)));

    assert_sp_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && sp_norm_in) |=> (mv_addr != $past(wr_addr)) ||
            (mv_data[74:64] == 11'($past(wr_data[30:23])) + 11'd896 && mv_data[63]));

    assert_op_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_data[31:11] == 21'd0 &&
        ((op_addr != mv_addr) || (op_data[95:32] == mv_data[95:32] && op_data[10:0] == mv_data[10:0])));
endmodule

bind fpimp_regfile fpimp_regfile_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_dbl  (wr_dbl),
    .wr_data (wr_data),
    .mv_addr (mv_addr),
    .mv_data (mv_data),
    .op_addr (op_addr),
    .op_data (op_data)
);

// File: tb/sim_fpimp_regfile.sv
module sim_fpimp_regfile;
    localparam int NREG = 10;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_dbl = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [AW-1:0] mv_addr = '0;
    logic [95:0]   mv_data;
    logic [AW-1:0] op_addr = '0;
    logic [95:0]   op_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpimp_regfile #(.NREG(NREG), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_dbl(wr_dbl), .wr_data(wr_data), .mv_addr(mv_addr),
        .mv_data(mv_data), .op_addr(op_addr), .op_data(op_data)
    );

    function automatic logic [95:0] mk(input logic s, input logic u, input logic v,
                                       input logic [10:0] e, input logic i, input logic [51:0] f);
        return {s, u, v, 18'd0, e, i, f, 11'd0};
    endfunction

    function automatic logic [95:0] ref_sp(input logic [31:0] d);
        logic s;
        logic [7:0] e;
        logic [22:0] f;
        logic [22:0] m;
        int sh;
        s = d[31]; e = d[30:23]; f = d[22:0];
        if (e == 0 && f == 0) return mk(s, 0, 0, 0, 0, 0);
        if (e == 0) begin
            m = f; sh = 0;
            while (m[22] == 1'b0) begin m = m << 1; sh++; end
            return mk(s, 1, 0, 11'(896 - sh), 1, {m[21:0], 30'd0});
        end
        if (e == 8'hFF) return mk(s, 0, 0, 11'd2047, 1, {f, 29'd0});
        return mk(s, 0, 0, 11'(int'(e) + 896), 1, {f, 29'd0});
    endfunction

    function automatic logic [95:0] ref_dp(input logic [63:0] d);
        logic [10:0] e;
        logic [51:0] f;
        e = d[62:52]; f = d[51:0];
        if (e == 0 && f == 0) return mk(d[63], 0, 0, 0, 0, 0);
        if (e == 0) return mk(d[63], 0, 1, 0, 0, f);
        return mk(d[63], 0, 0, e, 1, f);
    endfunction

    function automatic logic [95:0] trunc(input logic [95:0] w);
        logic [95:0] r;
        r = w;
        r[31:11] = 21'd0;
        return r;
    endfunction

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic dbl, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_dbl = dbl; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [95:0] exp);
        mv_addr = a; op_addr = a;
        #1;
        check(req, mv_data, exp);
        check({req, " op R8"}, op_data, trunc(exp));
    endtask

    task automatic sp_case(input string req, input int idx, input logic [31:0] d);
        logic [AW-1:0] a;
        a = AW'(idx % NREG);
        wr(a, 1'b0, {32'hDEAD_BEEF ^ 32'(idx), d});
        rd_check(req, a, ref_sp(d));
    endtask

    task automatic dp_case(input string req, input int idx, input logic [63:0] d);
        logic [AW-1:0] a;
        a = AW'(idx % NREG);
        wr(a, 1'b1, d);
        rd_check(req, a, ref_dp(d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [22:0] fp [4];
        logic [51:0] dfp [4];
        logic [95:0] prev;
        int idx;
        fp[0] = 23'h000000; fp[1] = 23'h400000; fp[2] = 23'h000001; fp[3] = 23'h2AAAAA;
        dfp[0] = 52'h0; dfp[1] = 52'h8000000000001; dfp[2] = 52'hFFFFFFFFFFFFF; dfp[3] = 52'h0000000000001;

        // R12: reset clears all entries
        repeat (3) @(posedge clk);
        #1;
        for (int a = 0; a < NREG; a++) rd_check("R12 reset", AW'(a), 96'd0);
        @(negedge clk) rst_n = 1'b1;
        for (int a = 0; a < NREG; a++) rd_check("R12 after release", AW'(a), 96'd0);

        // R1 R2 R3 R5 R10: single precision, all exponents, several fractions
        idx = 0;
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 4; k++) begin
                sp_case("R2/R3/R5/R10 sp sweep", idx, {idx[0], 8'(e), fp[k]});
                idx++;
            end
        end

        // R4: single-precision denormals, every leading-one position
        for (int b = 0; b < 23; b++) begin
            sp_case("R4 sp denorm bit", idx, {1'b0, 8'd0, 23'(1) << b});
            idx++;
            sp_case("R4 sp denorm mixed", idx, {1'b1, 8'd0, (23'(1) << b) | 23'd1});
            idx++;
        end

        // R6 R7 R5: double precision, all exponents
        for (int e = 0; e < 2048; e++) begin
            for (int k = 0; k < 4; k++) begin
                dp_case("R6/R7/R5 dp sweep", idx, {idx[1], 11'(e), dfp[k] ^ 52'(e)});
                idx++;
            end
        end

        // R5: tag cleared when an entry is overwritten by a non-denormal
        wr(AW'(2), 1'b0, 64'h0000_0000_0000_0001);
        rd_check("R5 sp tag set", AW'(2), ref_sp(32'h1));
        wr(AW'(2), 1'b1, 64'h3FF0_0000_0000_0000);
        rd_check("R5 tags cleared", AW'(2), mk(0, 0, 0, 11'd1023, 1, 0));

        // R8: truncation, no rounding of an all-ones fraction
        wr(AW'(4), 1'b1, 64'h4000_0000_001F_FFFF);
        mv_addr = AW'(4); op_addr = AW'(4); #1;
        check("R8 no round", op_data, mk(0, 0, 0, 11'h400, 1, 52'h0));

        // R10: upper half ignored in single mode
        wr(AW'(5), 1'b0, 64'h0000_0000_3F80_0000);
        prev = mv_data;
        wr(AW'(5), 1'b0, 64'hFFFF_FFFF_3F80_0000);
        mv_addr = AW'(5); op_addr = AW'(5); #1;
        check("R10 upper ignored", mv_data, mk(0, 0, 0, 11'd1023, 1, 0));

        // R9: new value not visible before the edge
        mv_addr = AW'(6); #1;
        prev = mv_data;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(6); wr_dbl = 1'b1; wr_data = 64'hC008_0000_0000_0000;
        #1 check("R9 before edge", mv_data, prev);
        @(posedge clk);
        #1 wr_en = 1'b0;
        check("R9 after edge", mv_data, ref_dp(64'hC008_0000_0000_0000));
        op_addr = AW'(5); #1;
        check("R9 ports independent", op_data, trunc(mk(0, 0, 0, 11'd1023, 1, 0)));

        // R11: out-of-range writes change nothing, reads return zero
        for (int a = 0; a < NREG; a++) wr(AW'(a), 1'b1, {1'b0, 11'(a + 1), 52'(a)});
        for (int a = NREG; a < 16; a++) wr(AW'(a), 1'b1, 64'hFFF0_0000_0000_0000);
        for (int a = 0; a < NREG; a++)
            rd_check("R11 entries kept", AW'(a), ref_dp({1'b0, 11'(a + 1), 52'(a)}));
        for (int a = NREG; a < 16; a++) rd_check("R11 read zero", AW'(a), 96'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule